// File: doc/BRIEF.md
# SDRAM Host Bridge

This block joins a simple synchronous host bus, shaped like an SRAM port, to an SDRAM command engine. The host presents a chip select, separate read and write strobes, a 23-bit byte address covering 8 MB, a two-bit transfer size and 32-bit write data. The bridge latches the request and stalls the host through an active-low busy line until the engine acknowledges. One transfer is handled at a time, with no bursts.

From each captured request the bridge splits the address into byte lane, column, bank and row fields. It builds a per-lane data mask and steers byte or half-word write data onto the addressed lanes. On reads it registers the returned word and, when the low-order alignment option is built in, shifts byte and half-word results down to bit 0. A write issued while the mode-select input is low is not sent as a memory write. Its low 11 data bits go to the engine as a mode-register value instead.

Top module: `sdram_host_bridge`

## Requirements
- R1: While reset is held low at a clock edge, busy is driven high, the engine request is low, all four lane masks are high (masked) and the host read bus is zero.
- R2: On the clock after chip select is low with exactly one of the read and write strobes low, busy goes low and the engine request goes high. The request carries column = address[9:2], bank = address[11:10] and row = address[22:12].
- R3: The engine request, busy and all request fields hold steady until the acknowledge is sampled. On the clock after that, the request drops and busy returns high.
- R4: The lane mask is active high (1 = lane masked). Size 2'b01 (byte) unmasks only lane address[1:0]. Size 2'b10 (half-word) unmasks lanes 1:0 when address[1] is 0 and lanes 3:2 when it is 1. Sizes 2'b00 (word) and 2'b11 unmask all lanes.
- R5: With alignment built in, byte write data[7:0] is copied to all four lanes and half-word data[15:0] to both halves. Without alignment, write data passes unchanged. Word writes always pass unchanged.
- R6: A read's data is registered on the acknowledge clock. With alignment, a byte comes back as lane address[1:0] in bits [7:0] and a half-word as the selected half in bits [15:0], upper bits zero. Without alignment, masked lanes are zeroed and the others keep their positions. The host read bus changes only when a read completes.
- R7: A write with the mode-select input low raises the mode request instead of the write request, forwards write data[10:0] as the mode value and masks all lanes. Mode-select low on a read has no effect.
- R8: Chip select low with both strobes low is ignored: no engine request is raised and busy stays high.
- R9: After a transfer completes, no new request is accepted until chip select goes high or both strobes go high.
- R10: Once a transfer completes, all lane masks return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_mode_n | input | 1 | Low on a write turns it into mode-register programming |
| host_size | input | 2 | Transfer size: 00 word, 01 byte, 10 half-word, 11 word |
| host_addr | input | 23 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data returned to the host |
| host_busy_n | output | 1 | Stall to the host, active low |
| eng_req | output | 1 | Request to the SDRAM engine |
| eng_write | output | 1 | Request is a memory write |
| eng_mode | output | 1 | Request is mode-register programming |
| eng_row | output | 11 | Row field |
| eng_bank | output | 2 | Bank field |
| eng_col | output | 8 | Column field |
| eng_dqm | output | 4 | Per-lane data mask, 1 = masked |
| eng_wdata | output | 32 | Lane-steered write data |
| eng_mode_val | output | 11 | Mode-register value |
| eng_ack | input | 1 | Engine completion acknowledge |
| eng_rdata | input | 32 | Engine read data, valid with the acknowledge |

## Verification
Completing a transfer and seeing a fresh request can fall in the same cycle. On the acknowledge clock the host still holds chip select and its strobe, because it only sees busy return high afterwards. The bench holds the strobes for two more cycles after every completion and requires that the request stays low and busy stays high in both. It then checks that the next transfer, issued right after release, is accepted on its first clock.

// File: rtl/sdram_bridge_pkg.sv
// Shared types for the SDRAM host bridge.
// Assumes a host size code of two bits and a three-phase request cycle.
package sdram_bridge_pkg;

    // Host transfer size codes; the wide code is treated as a word.
    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_WIDE = 2'b11
    } size_e;

    // Request cycle: waiting for a host strobe, waiting for the engine,
    // waiting for the host to drop its strobes.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_WAIT  = 2'b01,
        PH_DRAIN = 2'b10
    } phase_e;

endpackage

// File: rtl/bridge_addr_split.sv
// Splits a host byte address into lane, column, bank and row fields and
// builds the active-high lane mask for the requested transfer size.
// Assumes ADDR_W equals lane bits + column + bank + row bits.
module bridge_addr_split #(
    parameter int ADDR_W = 23,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 11,
    parameter int LANES  = 4,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [LANES-1:0]  dqm
);
    import sdram_bridge_pkg::*;

    localparam int COL_LO  = LANE_W;
    localparam int BANK_LO = COL_LO + COL_W;
    localparam int ROW_LO  = BANK_LO + BANK_W;

    logic [LANE_W-1:0] lane;

    // Field extraction from the word part of the address.
    assign lane = addr[LANE_W-1:0];
    assign col  = addr[COL_LO +: COL_W];
    assign bank = addr[BANK_LO +: BANK_W];
    assign row  = addr[ROW_LO +: ROW_W];

    // One mask bit per lane, chosen by size and lane index.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LANE_W-1:0] IDX = LANE_W'(g);
        assign dqm[g] = (size == SZ_BYTE) ? (lane != IDX) :
                        (size == SZ_HALF) ? (lane[LANE_W-1] != IDX[LANE_W-1]) :
                        1'b0;
    end

    // Byte transfers leave exactly one lane open.
    always_comb begin
        if (size == SZ_BYTE) begin
            assert_byte_one_lane_R4: assert ($countones(dqm) == LANES - 1)
                else $error("byte access must open exactly one lane");
        end
    end

endmodule

// File: rtl/bridge_wr_steer.sv
// Replicates byte or half-word write data onto every lane so that the
// lane mask alone selects the written bytes. Word data passes through.
// Assumes the host places sub-word data in the low-order bits.
module bridge_wr_steer #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int HALVES = LANES / 2
) (
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] wdata_o
);
    import sdram_bridge_pkg::*;

    // Replication by transfer size.
    always_comb begin
        case (size)
            SZ_BYTE: wdata_o = {LANES{wdata[7:0]}};
            SZ_HALF: wdata_o = {HALVES{wdata[15:0]}};
            default: wdata_o = wdata;
        endcase
    end

endmodule

// File: rtl/bridge_rd_align.sv
// Formats the engine's read word for the host. With ALIGN set, byte and
// half-word results are shifted down to bit 0; otherwise unselected
// lanes are zeroed and selected lanes keep their positions.
// Assumes lane and size come from the captured request.
module bridge_rd_align #(
    parameter int DATA_W = 32,
    parameter bit ALIGN  = 1'b1,
    localparam int LANES = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] rdata_o
);
    import sdram_bridge_pkg::*;

    if (ALIGN) begin : g_align
        logic [LANE_W-1:0] sel;
        logic [DATA_W-1:0] shifted;
        logic [DATA_W-1:0] keep;

        // Lane to move down to bit 0.
        always_comb begin
            case (size)
                SZ_BYTE: sel = lane;
                SZ_HALF: sel = {lane[LANE_W-1], {(LANE_W-1){1'b0}}};
                default: sel = '0;
            endcase
        end

        // Shift then trim to the transfer width.
        always_comb begin
            shifted = rdata >> {sel, 3'b000};
            case (size)
                SZ_BYTE: keep = DATA_W'({8{1'b1}});
                SZ_HALF: keep = DATA_W'({16{1'b1}});
                default: keep = '1;
            endcase
            rdata_o = shifted & keep;
        end
    end else begin : g_raw
        // Zero the lanes outside the transfer, keep positions.
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            localparam logic [LANE_W-1:0] IDX = LANE_W'(g);
            logic open;
            assign open = (size == SZ_BYTE) ? (lane == IDX) :
                          (size == SZ_HALF) ? (lane[LANE_W-1] == IDX[LANE_W-1]) :
                          1'b1;
            assign rdata_o[g*8 +: 8] = open ? rdata[g*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/sdram_host_bridge.sv
// SRAM-style host port in front of an SDRAM command engine.
// Latches one host transfer, stalls the host with an active-low busy,
// hands the split and masked request to the engine and returns read data.
// Assumes the host holds its request while busy is low and the engine
// answers every request with a single-cycle acknowledge.
module sdram_host_bridge #(
    parameter int ADDR_W    = 23,
    parameter int DATA_W    = 32,
    parameter int ROW_W     = 11,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 8,
    parameter int MODE_W    = 11,
    parameter bit ALIGN_LOW = 1'b1,
    localparam int LANES    = DATA_W / 8,
    localparam int LANE_W   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_mode_n,
    input  logic [1:0]        host_size,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_busy_n,
    output logic              eng_req,
    output logic              eng_write,
    output logic              eng_mode,
    output logic [ROW_W-1:0]  eng_row,
    output logic [BANK_W-1:0] eng_bank,
    output logic [COL_W-1:0]  eng_col,
    output logic [LANES-1:0]  eng_dqm,
    output logic [DATA_W-1:0] eng_wdata,
    output logic [MODE_W-1:0] eng_mode_val,
    input  logic              eng_ack,
    input  logic [DATA_W-1:0] eng_rdata
);
    import sdram_bridge_pkg::*;

    phase_e            phase;
    logic              busy_n_q, req_q, write_q, mode_q;
    logic [ROW_W-1:0]  row_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic [LANES-1:0]  dqm_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [MODE_W-1:0] modeval_q;
    logic [1:0]        size_q;
    logic [LANE_W-1:0] lane_q;

    logic              sel, rd_act, wr_act, start, held;
    logic [ROW_W-1:0]  row_d;
    logic [BANK_W-1:0] bank_d;
    logic [COL_W-1:0]  col_d;
    logic [LANES-1:0]  dqm_d;
    logic [DATA_W-1:0] wdata_d, rdata_d;

    // Strobe decode: a start needs exactly one strobe with chip select.
    assign sel    = ~host_cs_n;
    assign rd_act = ~host_rd_n;
    assign wr_act = ~host_wr_n;
    assign start  = sel & (rd_act ^ wr_act);
    assign held   = sel & (rd_act | wr_act);

    bridge_addr_split #(
        .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .LANES(LANES)
    ) u_split (
        .addr(host_addr), .size(host_size),
        .col(col_d), .bank(bank_d), .row(row_d), .dqm(dqm_d)
    );

    if (ALIGN_LOW) begin : g_steer
        bridge_wr_steer #(.DATA_W(DATA_W)) u_steer (
            .wdata(host_wdata), .size(host_size), .wdata_o(wdata_d)
        );
    end else begin : g_pass
        assign wdata_d = host_wdata;
    end

    bridge_rd_align #(.DATA_W(DATA_W), .ALIGN(ALIGN_LOW)) u_align (
        .rdata(eng_rdata), .size(size_q), .lane(lane_q), .rdata_o(rdata_d)
    );

    // Request cycle: capture, wait for acknowledge, wait for strobe release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            busy_n_q  <= 1'b1;
            req_q     <= 1'b0;
            write_q   <= 1'b0;
            mode_q    <= 1'b0;
            row_q     <= '0;
            bank_q    <= '0;
            col_q     <= '0;
            dqm_q     <= '1;
            wdata_q   <= '0;
            modeval_q <= '0;
            size_q    <= SZ_WORD;
            lane_q    <= '0;
            rdata_q   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_WAIT;
                        busy_n_q  <= 1'b0;
                        req_q     <= 1'b1;
                        write_q   <= wr_act & host_mode_n;
                        mode_q    <= wr_act & ~host_mode_n;
                        row_q     <= row_d;
                        bank_q    <= bank_d;
                        col_q     <= col_d;
                        dqm_q     <= (wr_act & ~host_mode_n) ? '1 : dqm_d;
                        wdata_q   <= wdata_d;
                        modeval_q <= host_wdata[MODE_W-1:0];
                        size_q    <= host_size;
                        lane_q    <= host_addr[LANE_W-1:0];
                    end
                end
                PH_WAIT: begin
                    if (eng_ack) begin
                        phase    <= PH_DRAIN;
                        busy_n_q <= 1'b1;
                        req_q    <= 1'b0;
                        write_q  <= 1'b0;
                        mode_q   <= 1'b0;
                        dqm_q    <= '1;
                        if (!write_q && !mode_q) begin
                            rdata_q <= rdata_d;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (!held) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign host_rdata   = rdata_q;
    assign host_busy_n  = busy_n_q;
    assign eng_req      = req_q;
    assign eng_write    = write_q;
    assign eng_mode     = mode_q;
    assign eng_row      = row_q;
    assign eng_bank     = bank_q;
    assign eng_col      = col_q;
    assign eng_dqm      = dqm_q;
    assign eng_wdata    = wdata_q;
    assign eng_mode_val = modeval_q;

    // Acceptance of a legal strobe from idle.
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start) |=> (eng_req && !host_busy_n));

    // Request and fields hold until acknowledged.
    assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && !host_busy_n && $stable(eng_dqm)
            && $stable(eng_row) && $stable(eng_col) && $stable(eng_wdata)));

    // Acknowledge ends the request on the next clock.
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_ack) |=> (!eng_req && host_busy_n));

    // Host read bus moves only on a completing transfer.
    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_req && eng_ack) |=> $stable(host_rdata));

    // Mode requests are never memory writes and keep every lane masked.
    assert_mode_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_mode |-> (!eng_write && eng_dqm == '1));

    // Both strobes at once never starts a request.
    assert_illegal_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && sel && rd_act && wr_act) |=> !eng_req);

    // Strobes still held after completion do not re-arm the request.
    assert_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DRAIN) |=> !eng_req);

    // Lanes are masked whenever no request is open.
    assert_idle_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_req |-> (eng_dqm == '1));

endmodule

// File: tb/sdram_host_bridge_test.sv
// Bench for the SDRAM host bridge: one aligned and one unaligned instance
// share the stimulus; the bench plays host and engine.
module sdram_host_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode_n = 1'b1;
    logic [1:0]  size = 2'b00;
    logic [22:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ack = 1'b0;
    logic [31:0] erdata = '0;

    logic [31:0] rdata, r_rdata, e_wdata, r_wdata;
    logic        busy_n, r_busy_n, req, r_req, e_write, r_write, e_mode, r_mode;
    logic [10:0] e_row, r_row, e_mval, r_mval;
    logic [1:0]  e_bank, r_bank;
    logic [7:0]  e_col, r_col;
    logic [3:0]  e_dqm, r_dqm;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] last_al = '0;
    logic [31:0] last_raw = '0;

    always #4 clk = ~clk;

    sdram_host_bridge uut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n),
        .host_wr_n(wr_n), .host_mode_n(mode_n), .host_size(size),
        .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
        .host_busy_n(busy_n), .eng_req(req), .eng_write(e_write),
        .eng_mode(e_mode), .eng_row(e_row), .eng_bank(e_bank), .eng_col(e_col),
        .eng_dqm(e_dqm), .eng_wdata(e_wdata), .eng_mode_val(e_mval),
        .eng_ack(ack), .eng_rdata(erdata)
    );

    sdram_host_bridge #(.ALIGN_LOW(1'b0)) uut_raw (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n),
        .host_wr_n(wr_n), .host_mode_n(mode_n), .host_size(size),
        .host_addr(addr), .host_wdata(wdata), .host_rdata(r_rdata),
        .host_busy_n(r_busy_n), .eng_req(r_req), .eng_write(r_write),
        .eng_mode(r_mode), .eng_row(r_row), .eng_bank(r_bank), .eng_col(r_col),
        .eng_dqm(r_dqm), .eng_wdata(r_wdata), .eng_mode_val(r_mval),
        .eng_ack(ack), .eng_rdata(erdata)
    );

    function automatic logic [3:0] f_dqm(input logic [1:0] sz, input logic [22:0] a);
        case (sz)
            2'b01:   return ~(4'b0001 << a[1:0]);
            2'b10:   return a[1] ? 4'b0011 : 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] f_wd(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'b01:   return {4{d[7:0]}};
            2'b10:   return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] f_rd_al(input logic [1:0] sz, input logic [22:0] a,
                                            input logic [31:0] e);
        case (sz)
            2'b01:   return (e >> (32'(a[1:0]) * 8)) & 32'h0000_00FF;
            2'b10:   return (e >> (32'(a[1]) * 16)) & 32'h0000_FFFF;
            default: return e;
        endcase
    endfunction

    function automatic logic [31:0] f_rd_raw(input logic [1:0] sz, input logic [22:0] a,
                                             input logic [31:0] e);
        logic [3:0]  m;
        logic [31:0] r;
        m = f_dqm(sz, a);
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? 8'h00 : e[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // One host transfer; called and returns at a falling edge.
    task automatic xfer(input bit is_wr, input bit is_mode, input logic [1:0] sz,
                        input logic [22:0] a, input logic [31:0] d,
                        input logic [31:0] e, input int delay);
        logic [3:0]  xdqm;
        bit          mw;
        cs_n = 1'b0; rd_n = is_wr; wr_n = !is_wr; mode_n = !is_mode;
        size = sz; addr = a; wdata = d;
        mw = is_wr && is_mode;
        xdqm = mw ? 4'hF : f_dqm(sz, a);
        @(negedge clk);
        chk(req && !busy_n, "R2 accept req/busy", {30'b0, req, busy_n}, 32'h2);
        chk(e_col == a[9:2], "R2 column", 32'(e_col), 32'(a[9:2]));
        chk(e_bank == a[11:10], "R2 bank", 32'(e_bank), 32'(a[11:10]));
        chk(e_row == a[22:12], "R2 row", 32'(e_row), 32'(a[22:12]));
        chk(e_dqm == xdqm, "R4 lane mask", 32'(e_dqm), 32'(xdqm));
        chk(e_write == (is_wr && !is_mode), "R7 write flag", 32'(e_write),
            32'(is_wr && !is_mode));
        chk(e_mode == mw, "R7 mode flag", 32'(e_mode), 32'(mw));
        if (mw) begin
            chk(e_mval == d[10:0], "R7 mode value", 32'(e_mval), 32'(d[10:0]));
        end
        if (is_wr && !is_mode) begin
            chk(e_wdata == f_wd(sz, d), "R5 aligned write data", e_wdata, f_wd(sz, d));
            chk(r_wdata == d, "R5 raw write data", r_wdata, d);
        end
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk(req && !busy_n && e_dqm == xdqm, "R3 hold while waiting",
                {27'b0, req, busy_n, e_dqm}, {27'b0, 1'b1, 1'b0, xdqm});
        end
        ack = 1'b1; erdata = e;
        @(negedge clk);
        ack = 1'b0; erdata = $urandom;
        chk(!req && busy_n, "R3 release after ack", {30'b0, req, busy_n}, 32'h1);
        chk(e_dqm == 4'hF, "R10 masks after completion", 32'(e_dqm), 32'hF);
        if (!is_wr) begin
            last_al  = f_rd_al(sz, a, e);
            last_raw = f_rd_raw(sz, a, e);
        end
        chk(rdata == last_al, "R6 aligned read data", rdata, last_al);
        chk(r_rdata == last_raw, "R6 raw read data", r_rdata, last_raw);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(!req && busy_n, "R9 held strobes not re-accepted",
                {30'b0, req, busy_n}, 32'h1);
        end
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; mode_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(busy_n && !req && e_dqm == 4'hF && rdata == 0, "R1 reset state",
            {26'b0, busy_n, req, e_dqm}, {26'b0, 1'b1, 1'b0, 4'hF});
        chk(r_busy_n && !r_req && r_dqm == 4'hF, "R1 reset state raw",
            {26'b0, r_busy_n, r_req, r_dqm}, {26'b0, 1'b1, 1'b0, 4'hF});
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: every lane and half for reads and writes.
        for (int l = 0; l < 4; l++) begin
            xfer(1'b0, 1'b0, 2'b01, 23'h12_3450 | 23'(l), 32'h0, 32'hA1B2_C3D4, l);
            xfer(1'b1, 1'b0, 2'b01, 23'h00_0400 | 23'(l), 32'h0000_005A, 32'h0, 1);
        end
        xfer(1'b0, 1'b0, 2'b10, 23'h7F_FFFE, 32'h0, 32'h1234_5678, 0);
        xfer(1'b0, 1'b0, 2'b10, 23'h00_0000, 32'h0, 32'h9ABC_DEF0, 2);
        xfer(1'b1, 1'b0, 2'b10, 23'h40_0002, 32'hFFFF_BEEF, 32'h0, 0);
        xfer(1'b0, 1'b0, 2'b11, 23'h2A_AAAB, 32'h0, 32'hCAFE_F00D, 1);
        xfer(1'b1, 1'b0, 2'b00, 23'h55_5554, 32'h0BAD_CAFE, 32'h0, 3);
        // Mode programming, and mode-select low on a read.
        xfer(1'b1, 1'b1, 2'b01, 23'h00_0003, 32'hFFFF_F237, 32'h0, 0);
        xfer(1'b0, 1'b1, 2'b01, 23'h00_0002, 32'h0, 32'h0011_2233, 1);

        // Illegal: both strobes with chip select.
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!req && busy_n, "R8 both strobes ignored", {30'b0, req, busy_n}, 32'h1);
        end
        chk(rdata == last_al, "R8 read bus untouched", rdata, last_al);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);

        // Random mix.
        for (int n = 0; n < 80; n++) begin
            xfer(1'($urandom), ($urandom % 8) == 0, 2'($urandom), 23'($urandom),
                 $urandom, $urandom, int'($urandom % 5));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule